// File: doc/BRIEF.md
# Code and Data Address Space Decoder

This block sits between a processor core and its memories. Each cycle it takes a 16-bit instruction-fetch address and a 16-bit data-transfer address. It decides whether each access is served by on-chip storage or by the external memory bus. Code addresses are split by a fixed 32 KB boundary. Whether that split applies at all depends on a boot pin, which is captured while reset is held. Data addresses are checked against a 1 KB on-chip RAM window at the very top of the 64 KB data space. A software-controlled enable bit decides whether that window is served on chip or passed to the external bus.

Data transfers may carry a full 16-bit address or a short 8-bit address. A short address takes its upper byte from a page register, which is written through its own port. Read data from the memories returns one cycle after the request. A pair of multiplexers remembers where each access was steered and presents the matching data. The memory arrays and the external bus timing lie outside this block. All enables and local addresses are combinational from the request, so they appear in the same cycle as the request.

Top module: `cds_decoder`

## Requirements
- R1: With the captured boot level at 1, a fetch (`fch_req`=1) to an address below 8000H asserts `rom_en`, drives `rom_addr` with address bits 14:0, and leaves `ext_code_req` low, all in the same cycle.
- R2: With the captured boot level at 1, a fetch to 8000H–FFFFH asserts `ext_code_req` with `ext_code_addr` equal to the full fetch address, and leaves `rom_en` low.
- R3: With the captured boot level at 0, every fetch asserts `ext_code_req` with the full address and never asserts `rom_en`.
- R4: `boot_int_pin` is sampled on every clock edge while `rst_n` is 0. The value from the last edge before release is held. Changes to the pin after release have no effect on steering.
- R5: With the on-chip enable at 1, a data read (`dat_rd`) or write (`dat_wr`) whose effective address is FC00H–FFFFH asserts `ram_rd`/`ram_wr` with `ram_addr` equal to effective address bits 9:0. No external data strobe is asserted.
- R6: A data access whose effective address is below FC00H, or any data access while the on-chip enable is 0, asserts `ext_dat_rd`/`ext_dat_wr` with `ext_dat_addr` equal to the effective address, and no on-chip RAM strobe.
- R7: With `dat_short`=1 the effective address is {page register, `dat_addr[7:0]`}, and `dat_addr[15:8]` is ignored. With `dat_short`=0 the effective address is `dat_addr`.
- R8: The page register resets to 00H and loads `pg_wdata` on a clock edge with `pg_wr`=1. An access in the same cycle as the write still uses the old page.
- R9: The on-chip enable resets to 1 and loads `en_wdata` on a clock edge with `en_wr`=1. An access in the same cycle as the write uses the old value.
- R10: In the cycle after a fetch, `fch_q` shows `rom_q` if that fetch went to ROM and `ext_code_q` otherwise. The choice is held through cycles without a fetch, and after reset it selects `ext_code_q`.
- R11: In the cycle after a data read, `dat_q` shows `ram_q` if the read went on chip and `ext_dat_q` otherwise. Data writes and idle cycles leave the choice unchanged, and after reset it selects `ext_dat_q`.
- R12: With no fetch request, `rom_en` and `ext_code_req` are 0. With neither `dat_rd` nor `dat_wr`, all four data strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous for boot sampling, asynchronous for registers |
| boot_int_pin | input | 1 | Boot level: 1 allows the on-chip ROM for low code addresses |
| fch_req | input | 1 | Instruction fetch request |
| fch_addr | input | 16 | Fetch address |
| dat_rd | input | 1 | Data read request |
| dat_wr | input | 1 | Data write request |
| dat_short | input | 1 | 1 selects paged 8-bit data addressing |
| dat_addr | input | 16 | Data address (only bits 7:0 used in short mode) |
| pg_wr | input | 1 | Page register write strobe |
| pg_wdata | input | 8 | Page register write value |
| en_wr | input | 1 | On-chip RAM enable write strobe |
| en_wdata | input | 1 | On-chip RAM enable write value |
| rom_en | output | 1 | On-chip ROM access enable |
| rom_addr | output | 15 | On-chip ROM local address |
| rom_q | input | 8 | On-chip ROM read data |
| ext_code_req | output | 1 | External code fetch request |
| ext_code_addr | output | 16 | External code address |
| ext_code_q | input | 8 | External code read data |
| fch_q | output | 8 | Fetch read data to the core |
| ram_rd | output | 1 | On-chip RAM read enable |
| ram_wr | output | 1 | On-chip RAM write enable |
| ram_addr | output | 10 | On-chip RAM local address |
| ram_q | input | 8 | On-chip RAM read data |
| ext_dat_rd | output | 1 | External data read strobe |
| ext_dat_wr | output | 1 | External data write strobe |
| ext_dat_addr | output | 16 | External data address |
| ext_dat_q | input | 8 | External data read data |
| dat_q | output | 8 | Data read value to the core |

## Verification
Enables, strobes and local addresses (R1–R3, R5–R7, R12) follow the request in the same cycle. The bench therefore drives a request shortly after a falling edge and checks these outputs one time step later, before the next rising edge. The page, enable and boot-level registers (R4, R8, R9) change only on a rising edge. The bench updates its own model of them after that edge, so an access made in the same cycle as a write is checked against the old value. The read multiplexers (R10, R11) are due one cycle after the access. At each following falling edge the bench sets fresh memory read values and compares `fch_q` and `dat_q` with its record of where the previous access went, before it drives the next request.

// File: rtl/cds_pkg.sv
package cds_pkg;
  localparam int unsigned CDS_AW     = 16;
  localparam int unsigned CDS_ROM_AW = 15;
  localparam int unsigned CDS_RAM_AW = 10;
  localparam int unsigned CDS_PG_W   = 8;
  localparam int unsigned CDS_DW     = 8;
  localparam int unsigned CDS_LO_W   = CDS_AW - CDS_PG_W;

  typedef logic [CDS_AW-1:0] addr_t;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} src_e;

  // code address falls in the on-chip ROM range
  function automatic logic rom_hit(addr_t a);
    return a[CDS_AW-1:CDS_ROM_AW] == '0;
  endfunction

  // data address falls in the top on-chip RAM window
  function automatic logic ram_hit(addr_t a);
    return &a[CDS_AW-1:CDS_RAM_AW];
  endfunction

  // effective data address for full or paged addressing
  function automatic addr_t eff_addr(logic short_mode, logic [CDS_PG_W-1:0] pg, addr_t a);
    return short_mode ? {pg, a[CDS_LO_W-1:0]} : a;
  endfunction
endpackage

// File: rtl/cds_strap.sv
module cds_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic strap
);
  // follows the pin on each edge while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) strap <= pin;
  end

  // R4: level is frozen once reset is released
  p_strap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap));
endmodule

// File: rtl/cds_code_dec.sv
module cds_code_dec
  import cds_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap,
  input  logic                  fch_req,
  input  addr_t                 fch_addr,
  output logic                  rom_en,
  output logic [CDS_ROM_AW-1:0] rom_addr,
  output logic                  ext_req,
  output addr_t                 ext_addr
);
  localparam int unsigned ROM_TOP = 2 ** CDS_ROM_AW;

  logic code_int_hit;
  assign code_int_hit = strap && rom_hit(fch_addr);

  assign rom_en   = fch_req && code_int_hit;
  assign ext_req  = fch_req && !code_int_hit;
  assign rom_addr = fch_addr[CDS_ROM_AW-1:0];
  assign ext_addr = fch_addr;

  // R1: low code addresses go on chip when the boot level is 1
  p_rom_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_req && strap && (32'(fch_addr) < ROM_TOP)) |-> (rom_en && !ext_req));
  // R2: high code addresses go to the bus with the full address
  p_ext_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_req && strap && (32'(fch_addr) >= ROM_TOP)) |-> (ext_req && !rom_en && ext_addr == fch_addr));
  // R3: boot level 0 sends all fetches outside
  p_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_req && !strap) |-> (ext_req && !rom_en));
  // R12: no strobe without a request, never both
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fch_req |-> (!rom_en && !ext_req));
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_en, ext_req}));
endmodule

// File: rtl/cds_data_dec.sv
module cds_data_dec
  import cds_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dat_rd,
  input  logic                  dat_wr,
  input  logic                  dat_short,
  input  addr_t                 dat_addr,
  input  logic                  pg_wr,
  input  logic [CDS_PG_W-1:0]   pg_wdata,
  input  logic                  en_wr,
  input  logic                  en_wdata,
  output logic                  ram_rd,
  output logic                  ram_wr,
  output logic [CDS_RAM_AW-1:0] ram_addr,
  output logic                  ext_rd,
  output logic                  ext_wr,
  output addr_t                 ext_addr
);
  logic [CDS_PG_W-1:0] page_q;
  logic                ram_en_q;
  addr_t               eff;
  logic                win_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      ram_en_q <= 1'b1;
    end else begin
      if (pg_wr) page_q   <= pg_wdata;
      if (en_wr) ram_en_q <= en_wdata;
    end
  end

  assign eff      = eff_addr(dat_short, page_q, dat_addr);
  assign win_hit  = ram_en_q && ram_hit(eff);
  assign ram_rd   = dat_rd && win_hit;
  assign ram_wr   = dat_wr && win_hit;
  assign ext_rd   = dat_rd && !win_hit;
  assign ext_wr   = dat_wr && !win_hit;
  assign ram_addr = eff[CDS_RAM_AW-1:0];
  assign ext_addr = eff;

  // R5: window accesses stay off the external bus
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_rd || dat_wr) && ram_en_q && (&ext_addr[CDS_AW-1:CDS_RAM_AW])) |-> (!ext_rd && !ext_wr));
  // R6: disabled window always goes outside
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en_q |-> (!ram_rd && !ram_wr));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd && ext_rd) && !(ram_wr && ext_wr));
  // R7: short mode forms the address from the page and the low byte
  p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dat_short |-> (ext_addr[CDS_AW-1:CDS_LO_W] == page_q && ext_addr[CDS_LO_W-1:0] == dat_addr[CDS_LO_W-1:0]));
  // R8: page loads on write, holds otherwise
  p_page_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |=> page_q == $past(pg_wdata));
  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_wr |=> $stable(page_q));
  // R9: enable loads on write
  p_en_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ram_en_q == $past(en_wdata));
  // R12: no data strobe without a request
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_rd && !dat_wr) |-> !(ram_rd || ram_wr || ext_rd || ext_wr));
endmodule

// File: rtl/cds_rdmux.sv
module cds_rdmux
  import cds_pkg::*;
#(
  parameter int unsigned DW = CDS_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          take_int,
  input  logic [DW-1:0] int_q,
  input  logic [DW-1:0] ext_q,
  output logic [DW-1:0] q
);
  src_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= SRC_EXT;
    else if (take) sel_q <= take_int ? SRC_INT : SRC_EXT;
  end

  assign q = (sel_q == SRC_INT) ? int_q : ext_q;

  // R10/R11: select follows the last read and holds otherwise
  p_sel_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((sel_q == SRC_INT) == $past(take_int)));
  p_sel_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(sel_q));
endmodule

// File: rtl/cds_decoder.sv
module cds_decoder
  import cds_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boot_int_pin,
  input  logic                  fch_req,
  input  logic [CDS_AW-1:0]     fch_addr,
  input  logic                  dat_rd,
  input  logic                  dat_wr,
  input  logic                  dat_short,
  input  logic [CDS_AW-1:0]     dat_addr,
  input  logic                  pg_wr,
  input  logic [CDS_PG_W-1:0]   pg_wdata,
  input  logic                  en_wr,
  input  logic                  en_wdata,
  output logic                  rom_en,
  output logic [CDS_ROM_AW-1:0] rom_addr,
  input  logic [CDS_DW-1:0]     rom_q,
  output logic                  ext_code_req,
  output logic [CDS_AW-1:0]     ext_code_addr,
  input  logic [CDS_DW-1:0]     ext_code_q,
  output logic [CDS_DW-1:0]     fch_q,
  output logic                  ram_rd,
  output logic                  ram_wr,
  output logic [CDS_RAM_AW-1:0] ram_addr,
  input  logic [CDS_DW-1:0]     ram_q,
  output logic                  ext_dat_rd,
  output logic                  ext_dat_wr,
  output logic [CDS_AW-1:0]     ext_dat_addr,
  input  logic [CDS_DW-1:0]     ext_dat_q,
  output logic [CDS_DW-1:0]     dat_q
);
  logic boot_lvl;

  cds_strap u_strap (
    .clk(clk), .rst_n(rst_n), .pin(boot_int_pin), .strap(boot_lvl)
  );

  cds_code_dec u_code (
    .clk(clk), .rst_n(rst_n), .strap(boot_lvl),
    .fch_req(fch_req), .fch_addr(fch_addr),
    .rom_en(rom_en), .rom_addr(rom_addr),
    .ext_req(ext_code_req), .ext_addr(ext_code_addr)
  );

  cds_data_dec u_data (
    .clk(clk), .rst_n(rst_n),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_short(dat_short), .dat_addr(dat_addr),
    .pg_wr(pg_wr), .pg_wdata(pg_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
    .ext_rd(ext_dat_rd), .ext_wr(ext_dat_wr), .ext_addr(ext_dat_addr)
  );

  cds_rdmux #(.DW(CDS_DW)) u_code_mux (
    .clk(clk), .rst_n(rst_n), .take(fch_req), .take_int(rom_en),
    .int_q(rom_q), .ext_q(ext_code_q), .q(fch_q)
  );

  cds_rdmux #(.DW(CDS_DW)) u_data_mux (
    .clk(clk), .rst_n(rst_n), .take(dat_rd), .take_int(ram_rd),
    .int_q(ram_q), .ext_q(ext_dat_q), .q(dat_q)
  );
endmodule

// File: tb/cds_decoder_tb.sv
`timescale 1ns/1ps
module cds_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_int_pin = 1'b1;
  logic fch_req = 0, dat_rd = 0, dat_wr = 0, dat_short = 0, pg_wr = 0, en_wr = 0, en_wdata = 0;
  logic [15:0] fch_addr = 0, dat_addr = 0;
  logic [7:0] pg_wdata = 0, rom_q = 0, ext_code_q = 0, ram_q = 0, ext_dat_q = 0;
  logic rom_en, ext_code_req, ram_rd, ram_wr, ext_dat_rd, ext_dat_wr;
  logic [14:0] rom_addr;
  logic [9:0] ram_addr;
  logic [15:0] ext_code_addr, ext_dat_addr;
  logic [7:0] fch_q, dat_q;

  int checks = 0, errors = 0;
  bit exp_strap, exp_en, exp_csrc, exp_dsrc;
  logic [7:0] exp_page;

  always #10 clk = ~clk;

  cds_decoder u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit code_goes_in(bit strap, logic [15:0] a);
    return strap && (a < 16'h8000);
  endfunction

  function automatic logic [15:0] data_eff(bit sh, logic [7:0] pg, logic [15:0] a);
    return sh ? {pg, a[7:0]} : a;
  endfunction

  function automatic bit data_goes_in(bit en, logic [15:0] e);
    return en && (e >= 16'hFC00);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit f, input logic [15:0] fa, input bit rd, input bit wr,
                      input bit sh, input logic [15:0] da, input bit pw, input logic [7:0] pd,
                      input bit ew, input bit ed);
    bit ci, di;
    logic [15:0] e;
    string ct, dt;
    rom_q = 8'($urandom); ext_code_q = 8'($urandom);
    ram_q = 8'($urandom); ext_dat_q = 8'($urandom);
    #1;
    chk("R10 fetch data mux", fch_q, exp_csrc ? rom_q : ext_code_q);
    chk("R11 data read mux", dat_q, exp_dsrc ? ram_q : ext_dat_q);
    fch_req = f; fch_addr = fa; dat_rd = rd; dat_wr = wr; dat_short = sh; dat_addr = da;
    pg_wr = pw; pg_wdata = pd; en_wr = ew; en_wdata = ed;
    #1;
    ci = code_goes_in(exp_strap, fa);
    ct = !f ? "R12 code idle" : (!exp_strap ? "R3 boot low" : (ci ? "R1 rom range" : "R2 high code"));
    chk(ct, {rom_en, ext_code_req}, {f && ci, f && !ci});
    if (f && ci) chk("R1 rom addr", rom_addr, fa[14:0]);
    if (f && !ci) chk(ct, ext_code_addr, fa);
    e = data_eff(sh, exp_page, da);
    di = data_goes_in(exp_en, e);
    dt = !(rd || wr) ? "R12 data idle" : (di ? "R5 window" : "R6 external data");
    chk(dt, {ram_rd, ram_wr, ext_dat_rd, ext_dat_wr}, {rd && di, wr && di, rd && !di, wr && !di});
    if ((rd || wr) && di) chk(sh ? "R7 short ram addr" : "R5 ram addr", ram_addr, e[9:0]);
    if ((rd || wr) && !di) chk(sh ? "R7 short ext addr" : "R6 ext addr", ext_dat_addr, e);
    @(posedge clk);
    if (f) exp_csrc = ci;
    if (rd) exp_dsrc = di;
    if (pw) exp_page = pd;
    if (ew) exp_en = ed;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset(input bit pin);
    @(negedge clk);
    rst_n = 0; boot_int_pin = pin;
    fch_req = 0; dat_rd = 0; dat_wr = 0; pg_wr = 0; en_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    exp_strap = pin; exp_page = 8'h00; exp_en = 1; exp_csrc = 0; exp_dsrc = 0;
    #1;
    chk("R10 reset select", fch_q, ext_code_q);
    chk("R11 reset select", dat_q, ext_dat_q);
    chk("R12 reset strobes", {rom_en, ext_code_req, ram_rd, ram_wr, ext_dat_rd, ext_dat_wr}, 0);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] bnd [4];
    void'($urandom(32'd4242));
    bnd[0] = 16'h7FFF; bnd[1] = 16'h8000; bnd[2] = 16'hFBFF; bnd[3] = 16'hFC00;
    for (int p = 1; p >= 0; p--) begin
      do_reset(p[0]);
      // R4: pin change after release must not alter steering
      boot_int_pin = ~p[0];
      for (int en = 1; en >= 0; en--) begin
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, en[0]);
        for (int i = 0; i < 4; i++) begin
          step(1, bnd[i], 1, 0, 0, bnd[i], 0, 0, 0, 0);
          step(1, bnd[i], 0, 1, 0, bnd[i], 1, bnd[i][15:8], 0, 0);
          step(0, 0, 1, 0, 1, {~bnd[i][15:8], bnd[i][7:0]}, 0, 0, 0, 0);
          idle();
        end
      end
      // R4: fetch at 0000H still follows the captured level
      step(1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R4 boot level held", {31'd0, exp_csrc}, {31'd0, p[0]});
    end

    do_reset(1);
    // R9: enable reset value is 1, top address goes on chip
    step(0, 0, 1, 0, 0, 16'hFFFF, 0, 0, 0, 0);
    // R8: same-cycle page write uses old page (00H -> external)
    step(0, 0, 1, 0, 1, 16'h12FF, 1, 8'hFC, 0, 0);
    // R7: next cycle uses page FCH, upper bits ignored
    step(0, 0, 1, 0, 1, 16'h12FF, 0, 0, 0, 0);
    // R9: same-cycle enable clear still uses old enable
    step(0, 0, 0, 1, 0, 16'hFC10, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0, 16'hFC10, 0, 0, 0, 0);
    // R11: a write does not move the read select
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 1, 0, 0, 16'hFD00, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 16'h0100, 0, 0, 0, 0);
    idle();

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] fa, da;
      bit rw;
      fa = 16'($urandom);
      da = 16'($urandom);
      if ($urandom_range(0, 3) == 0) fa = {1'b0, 15'($urandom)} ^ 16'h8000 * $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) da = 16'hFC00 | 16'($urandom_range(0, 1023));
      rw = $urandom_range(0, 1) == 1;
      step($urandom_range(0, 1) == 1, fa,
           $urandom_range(0, 2) == 0 ? rw : 1'b0,
           $urandom_range(0, 2) == 0 ? !rw : 1'b0,
           $urandom_range(0, 1) == 1, da,
           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1 ? 8'hFC + 8'($urandom_range(0, 3)) : 8'($urandom),
           $urandom_range(0, 15) == 0, $urandom_range(0, 3) != 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule